// File: doc/BRIEF.md
# Decode-Stage Hazard Stall Unit

This block decides, every cycle, whether the instruction in decode may advance in a five-stage in-order pipeline. The stages are fetch, decode/register-read, execute, memory and write-back. Conditional branches compare their two operands in decode, and those operands are forwarded there. An operand that is not yet produced anywhere in the pipeline forces the decode instruction to wait. The block looks at the decode instruction's source registers and its operand class. It also looks at the destination, write-enable and load flag of the instructions now in execute and in memory.

On a stall the block drops `pc_write` and `ifid_write`, so the program counter and the fetch/decode register keep their values and the held instruction is decoded again on the next cycle. It also raises `ctrl_zero`, so the control fields entering execute are loaded with zeros and a bubble goes down the pipe. The block is purely combinational. The forwarding multiplexers, the comparator, the ALU and the memories belong to neighbouring logic.

The timing rules are these. A load feeding the next instruction costs one cycle. An ALU result feeding the next instruction costs one cycle when that instruction is a branch. A load feeding the next instruction costs two cycles when that instruction is a branch. In that last case the first cycle is spent with the load in execute and the second with the load in memory.

Top module: `hzd_stall_unit`

## Requirements
- R1: `id_kind` sets which sources are read: 3'd1 (register op) and 3'd3 (store, whose data register is `id_rt`) read both `id_rs` and `id_rt`. 3'd2 (immediate op or load) reads only `id_rs`. 3'd4 (branch) reads both. 3'd0 (jump or none) and codes 3'd5 to 3'd7 read nothing.
- R2: When the execute stage holds a load (`ex_ld`=1, `ex_wr`=1) whose `ex_rd` equals a source read by decode, the block stalls, whatever the decode instruction's class.
- R3: When the execute stage holds a non-load producer whose `ex_rd` equals a source read by a branch in decode, the block stalls. The same match with a non-branch reader does not stall.
- R4: When the memory stage holds a load whose `mem_rd` equals a source read by a branch in decode, the block stalls. The same match with a non-branch reader does not stall.
- R5: A non-load producer in the memory stage never causes a stall.
- R6: A destination of register 0 never counts as a producer.
- R7: A stage with its write-enable low is never a producer, even when its load flag is set.
- R8: While stalling, `pc_write`=0, `ifid_write`=0 and `ctrl_zero`=1. Otherwise the outputs are 1, 1 and 0.
- R9: A match on a source that the decode class does not read has no effect: a jump never stalls, and an immediate op ignores `id_rt`.
- R10: A load followed at once by a dependent branch stalls for exactly two consecutive cycles: first with the load in execute, then with the load in memory and a bubble in execute. The branch then proceeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_kind | input | 3 | Operand class of the decode instruction (codes in R1) |
| id_rs | input | REG_W | First source register in decode |
| id_rt | input | REG_W | Second source register in decode |
| ex_rd | input | REG_W | Destination register of the execute-stage instruction |
| ex_wr | input | 1 | Register-write control of the execute-stage instruction |
| ex_ld | input | 1 | Execute-stage instruction reads data memory |
| mem_rd | input | REG_W | Destination register of the memory-stage instruction |
| mem_wr | input | 1 | Register-write control of the memory-stage instruction |
| mem_ld | input | 1 | Memory-stage instruction reads data memory |
| pc_write | output | 1 | Program counter may update |
| ifid_write | output | 1 | Fetch/decode register may load |
| ctrl_zero | output | 1 | Zero the control fields entering execute |

## Verification
An execute-stage match and a memory-stage match can occur in the same cycle on different operands. They can also occur together with one stage stalling and the other forwarding. The vector table provokes this with a branch whose `id_rs` hits a non-load in execute while its `id_rt` hits a load in memory. It also has a register op whose two sources hit non-load producers in both stages. The first row must give one ordinary stall and the second none, and the outputs are judged as a single set. The two-cycle load-to-branch case is driven as a cycle sequence that moves the load from execute into memory behind a bubble.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  typedef enum logic [2:0] {
    K_NONE   = 3'd0,
    K_REG    = 3'd1,
    K_IMM    = 3'd2,
    K_STORE  = 3'd3,
    K_BRANCH = 3'd4
  } op_kind_e;

  // Number of producer stages watched (execute, memory).
  localparam int NUM_STAGES = 2;
  // Stage index after which a load result exists.
  localparam int LOAD_READY_STAGE = 1;
endpackage

// File: rtl/hzd_src_decode.sv
module hzd_src_decode
  import hzd_pkg::*;
(
  input  logic [2:0] kind,
  output logic       use_a,
  output logic       use_b,
  output logic       is_branch
);
  op_kind_e k;

  always_comb begin
    k         = op_kind_e'(kind);
    use_a     = 1'b0;
    use_b     = 1'b0;
    is_branch = 1'b0;
    unique case (k)
      K_REG, K_STORE: begin
        use_a = 1'b1;
        use_b = 1'b1;
      end
      K_IMM: use_a = 1'b1;
      K_BRANCH: begin
        use_a     = 1'b1;
        use_b     = 1'b1;
        is_branch = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/hzd_stage_match.sv
module hzd_stage_match #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src_a,
  input  logic [REG_W-1:0] src_b,
  input  logic             use_a,
  input  logic             use_b,
  input  logic [REG_W-1:0] dst,
  input  logic             wr_en,
  output logic             hit
);
  logic producer;

  // Register zero is hard-wired, so writing it produces nothing.
  assign producer = wr_en && (dst != '0);
  assign hit = producer &&
               ((use_a && (src_a == dst)) || (use_b && (src_b == dst)));
endmodule

// File: rtl/hzd_stall_combine.sv
module hzd_stall_combine #(
  parameter int NSTG       = 2,
  parameter int LOAD_READY = 1
) (
  input  logic [NSTG-1:0] hit,
  input  logic [NSTG-1:0] is_load,
  input  logic            is_branch,
  output logic            stall
);
  logic [NSTG-1:0] need;

  // A branch needs its operands in decode; other readers need them one
  // stage later, in execute. Stage s holds its result after stage
  // "ready" completes: loads after LOAD_READY, other ops after 0.
  for (genvar s = 0; s < NSTG; s++) begin : g_stage
    localparam bit LD_BR  = (s <= LOAD_READY);
    localparam bit LD_OTH = (s <  LOAD_READY);
    localparam bit AL_BR  = (s == 0);
    assign need[s] = hit[s] &&
                     (is_load[s] ? (is_branch ? LD_BR : LD_OTH)
                                 : (is_branch && AL_BR));
  end

  assign stall = |need;
endmodule

// File: rtl/hzd_stall_unit.sv
module hzd_stall_unit
  import hzd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [2:0]       id_kind,
  input  logic [REG_W-1:0] id_rs,
  input  logic [REG_W-1:0] id_rt,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_wr,
  input  logic             ex_ld,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             mem_wr,
  input  logic             mem_ld,
  output logic             pc_write,
  output logic             ifid_write,
  output logic             ctrl_zero
);
  localparam int NSTG = NUM_STAGES;

  logic             use_a, use_b, is_branch;
  logic [REG_W-1:0] stg_dst [NSTG];
  logic [NSTG-1:0]  stg_wr, stg_ld, stg_hit;
  logic             stall;

  assign stg_dst[0] = ex_rd;
  assign stg_dst[1] = mem_rd;
  assign stg_wr     = {mem_wr, ex_wr};
  assign stg_ld     = {mem_ld, ex_ld};

  hzd_src_decode u_src (
    .kind      (id_kind),
    .use_a     (use_a),
    .use_b     (use_b),
    .is_branch (is_branch)
  );

  for (genvar s = 0; s < NSTG; s++) begin : g_match
    hzd_stage_match #(.REG_W(REG_W)) u_match (
      .src_a (id_rs),
      .src_b (id_rt),
      .use_a (use_a),
      .use_b (use_b),
      .dst   (stg_dst[s]),
      .wr_en (stg_wr[s]),
      .hit   (stg_hit[s])
    );
  end

  hzd_stall_combine #(.NSTG(NSTG), .LOAD_READY(LOAD_READY_STAGE)) u_comb (
    .hit       (stg_hit),
    .is_load   (stg_ld),
    .is_branch (is_branch),
    .stall     (stall)
  );

  assign pc_write   = !stall;
  assign ifid_write = !stall;
  assign ctrl_zero  = stall;
endmodule

// File: rtl/hzd_stall_unit_chk.sv
module hzd_stall_unit_chk #(
  parameter int REG_W = 5
) (
  input logic [2:0]       id_kind,
  input logic [REG_W-1:0] ex_rd,
  input logic             ex_wr,
  input logic [REG_W-1:0] mem_rd,
  input logic             mem_wr,
  input logic             mem_ld,
  input logic             pc_write,
  input logic             ifid_write,
  input logic             ctrl_zero
);
  logic known;

  always_comb begin
    known = !$isunknown({id_kind, ex_rd, ex_wr, mem_rd, mem_wr, mem_ld,
                         pc_write, ifid_write, ctrl_zero});
    if (known) begin
      p_freeze_pair_r8: assert (pc_write == ifid_write)
        else $error("PC and fetch/decode enables disagree");
      p_bubble_r8: assert (ctrl_zero == !pc_write)
        else $error("bubble does not match freeze");
      p_zero_reg_r6: assert (!((ex_rd == '0) && (mem_rd == '0)) || !ctrl_zero)
        else $error("stall with only register 0 as destination");
      p_no_writer_r7: assert (ex_wr || mem_wr || !ctrl_zero)
        else $error("stall with no stage writing");
      p_jump_r9: assert ((id_kind != 3'd0) || pc_write)
        else $error("jump stalled");
      p_mem_alu_r5: assert (ex_wr || mem_ld || !ctrl_zero)
        else $error("stall from a non-load in memory alone");
    end
  end
endmodule

bind hzd_stall_unit hzd_stall_unit_chk #(.REG_W(REG_W)) u_chk (
  .id_kind    (id_kind),
  .ex_rd      (ex_rd),
  .ex_wr      (ex_wr),
  .mem_rd     (mem_rd),
  .mem_wr     (mem_wr),
  .mem_ld     (mem_ld),
  .pc_write   (pc_write),
  .ifid_write (ifid_write),
  .ctrl_zero  (ctrl_zero)
);

// File: tb/hzd_stall_unit_tb.sv
module hzd_stall_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int REG_W = 5;

  typedef struct packed {
    logic [2:0] kind;
    logic [4:0] rs;
    logic [4:0] rt;
    logic [4:0] exrd;
    logic       exwr;
    logic       exld;
    logic [4:0] memrd;
    logic       memwr;
    logic       memld;
    logic       stall;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{3'd1, 5'd8, 5'd9, 5'd8, 1'b1, 1'b1, 5'd0, 1'b0, 1'b0, 1'b1, 4'd2},  // R2 load->rs
    '{3'd1, 5'd8, 5'd9, 5'd9, 1'b1, 1'b1, 5'd0, 1'b0, 1'b0, 1'b1, 4'd2},  // R2 load->rt
    '{3'd1, 5'd8, 5'd9, 5'd8, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 4'd3},  // R3 alu->reg op
    '{3'd4, 5'd8, 5'd9, 5'd8, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1, 4'd3},  // R3 alu->branch
    '{3'd4, 5'd8, 5'd9, 5'd9, 1'b1, 1'b1, 5'd0, 1'b0, 1'b0, 1'b1, 4'd2},  // R2 load->branch
    '{3'd4, 5'd8, 5'd9, 5'd0, 1'b0, 1'b0, 5'd8, 1'b1, 1'b1, 1'b1, 4'd4},  // R4 mem load->branch
    '{3'd1, 5'd8, 5'd9, 5'd0, 1'b0, 1'b0, 5'd8, 1'b1, 1'b1, 1'b0, 4'd4},  // R4 mem load->reg op
    '{3'd4, 5'd8, 5'd9, 5'd0, 1'b0, 1'b0, 5'd8, 1'b1, 1'b0, 1'b0, 4'd5},  // R5 mem alu->branch
    '{3'd4, 5'd0, 5'd0, 5'd0, 1'b1, 1'b0, 5'd0, 1'b1, 1'b1, 1'b0, 4'd6},  // R6 reg zero
    '{3'd1, 5'd8, 5'd9, 5'd8, 1'b0, 1'b1, 5'd9, 1'b0, 1'b1, 1'b0, 4'd7},  // R7 no write
    '{3'd0, 5'd8, 5'd9, 5'd8, 1'b1, 1'b1, 5'd9, 1'b1, 1'b1, 1'b0, 4'd9},  // R9 jump
    '{3'd2, 5'd8, 5'd9, 5'd9, 1'b1, 1'b1, 5'd0, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 imm ignores rt
    '{3'd3, 5'd1, 5'd9, 5'd9, 1'b1, 1'b1, 5'd0, 1'b0, 1'b0, 1'b1, 4'd1},  // R1 store data
    '{3'd7, 5'd8, 5'd9, 5'd8, 1'b1, 1'b1, 5'd9, 1'b1, 1'b1, 1'b0, 4'd1},  // R1 unused code
    '{3'd1, 5'd3, 5'd4, 5'd5, 1'b1, 1'b1, 5'd6, 1'b1, 1'b1, 1'b0, 4'd8},  // R8 unrelated
    '{3'd4, 5'd8, 5'd9, 5'd8, 1'b1, 1'b0, 5'd9, 1'b1, 1'b1, 1'b1, 4'd3},  // R3 both stages
    '{3'd1, 5'd8, 5'd9, 5'd8, 1'b1, 1'b0, 5'd9, 1'b1, 1'b0, 1'b0, 4'd5}   // R5 both stages alu
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0]       id_kind;
  logic [REG_W-1:0] id_rs, id_rt, ex_rd, mem_rd;
  logic             ex_wr, ex_ld, mem_wr, mem_ld;
  logic             pc_write, ifid_write, ctrl_zero;
  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hzd_stall_unit #(.REG_W(REG_W)) u_dut (
    .id_kind    (id_kind),
    .id_rs      (id_rs),
    .id_rt      (id_rt),
    .ex_rd      (ex_rd),
    .ex_wr      (ex_wr),
    .ex_ld      (ex_ld),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .mem_ld     (mem_ld),
    .pc_write   (pc_write),
    .ifid_write (ifid_write),
    .ctrl_zero  (ctrl_zero)
  );

  task automatic drive(input logic [2:0] k, input logic [4:0] rs, input logic [4:0] rt,
                       input logic [4:0] erd, input logic ewr, input logic eld,
                       input logic [4:0] mrd, input logic mwr, input logic mld);
    @(negedge clk);
    id_kind = k; id_rs = rs; id_rt = rt;
    ex_rd = erd; ex_wr = ewr; ex_ld = eld;
    mem_rd = mrd; mem_wr = mwr; mem_ld = mld;
    #1;
  endtask

  task automatic check(input string tag, input logic exp_stall);
    logic [2:0] act, exp;
    act = {pc_write, ifid_write, ctrl_zero};
    exp = exp_stall ? 3'b001 : 3'b110;
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {pc_write,ifid_write,ctrl_zero} actual %b expected %b", tag, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    drive(3'd0, '0, '0, '0, 1'b0, 1'b0, '0, 1'b0, 1'b0);
    repeat (2) @(posedge clk);
    rst = 1'b0;
    #1;
    check("R8 reset idle", 1'b0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].kind, VEC[i].rs, VEC[i].rt, VEC[i].exrd, VEC[i].exwr, VEC[i].exld,
            VEC[i].memrd, VEC[i].memwr, VEC[i].memld);
      check($sformatf("R%0d vector %0d", VEC[i].req, i), VEC[i].stall);
    end

    // R10: load r8 then branch on r8; two stall cycles, then release.
    drive(3'd4, 5'd8, 5'd2, 5'd8, 1'b1, 1'b1, 5'd3, 1'b1, 1'b0);
    check("R10 cycle 1 load in execute", 1'b1);
    drive(3'd4, 5'd8, 5'd2, 5'd0, 1'b0, 1'b0, 5'd8, 1'b1, 1'b1);
    check("R10 cycle 2 load in memory", 1'b1);
    drive(3'd4, 5'd8, 5'd2, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0);
    check("R10 cycle 3 branch proceeds", 1'b0);

    // R3: ALU then branch; one stall, then forwarding from memory suffices.
    drive(3'd4, 5'd2, 5'd7, 5'd7, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0);
    check("R3 alu->branch stall", 1'b1);
    drive(3'd4, 5'd2, 5'd7, 5'd0, 1'b0, 1'b0, 5'd7, 1'b1, 1'b0);
    check("R5 alu in memory releases branch", 1'b0);

    // R6: register 0 loaded in execute, reg op reads register 0.
    drive(3'd1, 5'd0, 5'd0, 5'd0, 1'b1, 1'b1, 5'd0, 1'b1, 1'b1);
    check("R6 load to register 0", 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule